// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block sits beside a small 8-bit processor core and decides which of six interrupt sources is serviced next. There are two active-low external request pins, three timer overflow events and a serial port event. Each pin is conditioned through a two-flop synchronizer and then read either as a level or as a falling edge. Request flags are latched, masked by a per-source enable and a global enable, and split into two priority classes. When a source is chosen, the block raises a call request towards the core together with the vector address of that source. It holds both until the core acknowledges that it has started the long call.

Nesting has two levels. An in-service bit is kept for each level and is set when a call of that level is acknowledged. A high-class request can interrupt a running low-class handler. Any other request waits until the return-from-interrupt pulse clears the blocking in-service bit. The return pulse always clears the highest in-service bit that is set.

The sequencing is a two-state machine. `ST_IDLE` evaluates the masked requests on every clock and moves to `ST_CALL` when an eligible source exists, recording the winner and its level (transition *grant*). `ST_CALL` drives `call_req` and the vector. On `call_ack` it marks the level in service, clears the source flag where that is automatic, and returns to `ST_IDLE` (transition *accept*). Without an acknowledge it stays in `ST_CALL` (transition *hold*).

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `en_q`, `pri_q`, `flags` and `in_service` are zero and `call_req` is low.
- R2: Source bit positions are shared by `en_q` and `pri_q`: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2. Bit 7 of `en_q` is the global enable. Bit 6 of `en_q` and bits 7 and 6 of `pri_q` always read 0. A `pri_q` bit of 1 places the source in the high class.
- R3: No call is raised while `en_q[7]` is 0 or while the pending source's own enable bit is 0. The flag stays latched and is visible on `flags`.
- R4: Among eligible sources of the same class, the one with the lowest bit index wins.
- R5: An eligible high-class source wins over any low-class source, whatever their indices.
- R6: The vector equals 0x0003 + 8 × index. This gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B for indices 0 to 5.
- R7: `call_req` and `call_vec` stay stable until `call_ack`. On acknowledge, a timer flag or an edge-mode external flag clears. The serial flag (`flags[4]`) clears only on `ser_clr`.
- R8: Acknowledging a call sets `in_service[1]` for a high-class call and `in_service[0]` for a low-class one. A low-class source is eligible only when `in_service` is 0. A high-class source is eligible only when `in_service[1]` is 0.
- R9: A `reti` pulse clears `in_service[1]` if it is set, and otherwise clears `in_service[0]`.
- R10: With `ext_edge_mode[i]` = 1, a high-to-low transition on `ext_pin_n[i]` sets the flag. The flag appears on `flags` three rising edges after the pin changes. It stays set while the pin remains low and clears only when the vector is taken.
- R11: With `ext_edge_mode[i]` = 0, the external flag equals the inverted synchronized pin, two rising edges behind the pin. It is not cleared by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register write data |
| en_q | output | 8 | Enable register contents |
| pri_q | output | 8 | Priority register contents |
| ext_pin_n | input | 2 | External request pins, active low, asynchronous |
| ext_edge_mode | input | 2 | Per pin: 1 = falling edge, 0 = level |
| tmr_ovf | input | 3 | Overflow pulses of timers 0, 1, 2 |
| ser_set | input | 1 | Serial event pulse, sets the serial flag |
| ser_clr | input | 1 | Software clear of the serial flag |
| call_req | output | 1 | Call request to the core |
| call_vec | output | 16 | Vector address of the granted source |
| call_ack | input | 1 | Core has begun the call |
| reti | input | 1 | Return-from-interrupt pulse |
| flags | output | 6 | Pending request per source, bit order as R2 |
| in_service | output | 2 | In-service bits, [1] high class, [0] low class |

## Verification
The assertions assume that the core raises `call_ack` only while `call_req` is high. They also assume that `reti` is never pulsed in the same cycle as an acknowledge, and only while some level is in service. The bench follows these rules: it acknowledges only after it has seen `call_req` and it returns only after a handler has been entered. The external pins are driven on the falling clock edge, so the synchronizer sees clean transitions, and the reference model takes the same two-flop latency for granted.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC   = 6;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int SRC_SERIAL = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALL = 1'b1
    } arb_state_t;

    function automatic logic [15:0] vector_of(input logic [IDX_W-1:0] idx);
        return 16'h0003 + {10'd0, idx, 3'b000};
    endfunction
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic taken,
    output logic req
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;
    logic                   latch_q;
    logic                   synced;
    logic                   fall;

    assign synced = chain[SYNC_STAGES-1];
    assign fall   = prev_q & ~synced;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= pin_n;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= synced;
            if (fall)       latch_q <= 1'b1;
            else if (taken) latch_q <= 1'b0;
        end
    end

    assign req = edge_mode ? latch_q : ~synced;

    assert_edge_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && fall |=> latch_q);
endmodule

// File: rtl/irq_evt_flag.sv
module irq_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q && !clr |=> q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0]         en,
    input  logic [N-1:0]         hi,
    input  logic                 gie,
    input  logic [1:0]           ins,
    output logic                 valid,
    output logic [$clog2(N)-1:0] idx,
    output logic                 lvl
);
    localparam int W = $clog2(N);

    logic [N-1:0] cand_hi;
    logic [N-1:0] cand_lo;
    logic         hv, lv;
    logic [W-1:0] hidx, lidx;

    assign cand_hi = req & en &  hi & {N{gie & ~ins[1]}};
    assign cand_lo = req & en & ~hi & {N{gie & ~(|ins)}};

    always_comb begin
        hv = 1'b0; lv = 1'b0;
        hidx = '0; lidx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_hi[i]) begin hv = 1'b1; hidx = W'(i); end
            if (cand_lo[i]) begin lv = 1'b1; lidx = W'(i); end
        end
        valid = hv | lv;
        lvl   = hv;
        idx   = hv ? hidx : lidx;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter bit HAS_T2      = 1'b1,
    parameter int NUM_EXT     = 2,
    parameter int NUM_TMR     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_we,
    input  logic [7:0]  en_wdata,
    input  logic        pri_we,
    input  logic [7:0]  pri_wdata,
    output logic [7:0]  en_q,
    output logic [7:0]  pri_q,
    input  logic [1:0]  ext_pin_n,
    input  logic [1:0]  ext_edge_mode,
    input  logic [2:0]  tmr_ovf,
    input  logic        ser_set,
    input  logic        ser_clr,
    output logic        call_req,
    output logic [15:0] call_vec,
    input  logic        call_ack,
    input  logic        reti,
    output logic [5:0]  flags,
    output logic [1:0]  in_service
);
    localparam logic [7:0] EN_MASK  = {2'b10, HAS_T2, 5'h1F};
    localparam logic [7:0] PRI_MASK = {2'b00, HAS_T2, 5'h1F};

    arb_state_t       state_q, state_d;
    logic [IDX_W-1:0] win_q;
    logic             lvl_q;
    logic [1:0]       ins_q;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  taken;
    logic             accept;
    logic             pk_valid;
    logic [IDX_W-1:0] pk_idx;
    logic             pk_lvl;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 8'h00;
            pri_q <= 8'h00;
        end else begin
            if (en_we)  en_q  <= en_wdata  & EN_MASK;
            if (pri_we) pri_q <= pri_wdata & PRI_MASK;
        end
    end

    assign accept = (state_q == ST_CALL) && call_ack;

    always_comb begin
        taken = '0;
        if (accept) taken[win_q] = 1'b1;
    end

    // external pins feed even indices 0, 2
    generate
        for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
            irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_n     (ext_pin_n[e]),
                .edge_mode (ext_edge_mode[e]),
                .taken     (taken[2*e]),
                .req       (req[2*e])
            );
        end
        // timers feed odd indices 1, 3, 5
        for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
            if (t == 2 && !HAS_T2) begin : g_absent
                assign req[2*t+1] = 1'b0;
            end else begin : g_present
                irq_evt_flag u_flag (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .set   (tmr_ovf[t]),
                    .clr   (taken[2*t+1]),
                    .q     (req[2*t+1])
                );
            end
        end
    endgenerate

    irq_evt_flag u_serial (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ser_set),
        .clr   (ser_clr),
        .q     (req[SRC_SERIAL])
    );

    irq_pick #(.N(NSRC)) u_pick (
        .req   (req),
        .en    (en_q[NSRC-1:0]),
        .hi    (pri_q[NSRC-1:0]),
        .gie   (en_q[7]),
        .ins   (ins_q),
        .valid (pk_valid),
        .idx   (pk_idx),
        .lvl   (pk_lvl)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pk_valid) state_d = ST_CALL;
            ST_CALL: if (call_ack) state_d = ST_IDLE;
        endcase
    end

    // state register with winner capture and in-service tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
            lvl_q   <= 1'b0;
            ins_q   <= 2'b00;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pk_valid) begin
                win_q <= pk_idx;
                lvl_q <= pk_lvl;
            end
            begin
                logic [1:0] ins_n;
                ins_n = ins_q;
                if (reti) begin
                    if (ins_q[1]) ins_n[1] = 1'b0;
                    else          ins_n[0] = 1'b0;
                end
                if (accept) ins_n[lvl_q] = 1'b1;
                ins_q <= ins_n;
            end
        end
    end

    // output decode
    always_comb begin
        call_req = 1'b0;
        call_vec = 16'h0000;
        unique case (state_q)
            ST_IDLE: ;
            ST_CALL: begin
                call_req = 1'b1;
                call_vec = vector_of(win_q);
            end
        endcase
    end

    assign flags      = req;
    assign in_service = ins_q;

    assert_call_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && !call_ack |=> call_req && $stable(call_vec));
    assert_vec_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec[2:0] == 3'b011) && (call_vec < 16'h0030));
    assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && call_ack |=> in_service != 2'b00);
    assert_no_call_over_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !in_service[1]);
    assert_reti_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reti && in_service == 2'b11 && !call_ack |=> in_service == 2'b01);
    assert_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(en_q[7]));
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_we = 0, pri_we = 0;
    logic [7:0]  en_wdata = 0, pri_wdata = 0;
    logic [7:0]  en_q, pri_q;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  ext_edge_mode = 2'b00;
    logic [2:0]  tmr_ovf = 0;
    logic        ser_set = 0, ser_clr = 0;
    logic        call_req;
    logic [15:0] call_vec;
    logic        call_ack = 0, reti = 0;
    logic [5:0]  flags;
    logic [1:0]  in_service;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
        .pri_we(pri_we), .pri_wdata(pri_wdata), .en_q(en_q), .pri_q(pri_q),
        .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode), .tmr_ovf(tmr_ovf),
        .ser_set(ser_set), .ser_clr(ser_clr), .call_req(call_req),
        .call_vec(call_vec), .call_ack(call_ack), .reti(reti),
        .flags(flags), .in_service(in_service)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [1:0] m_s1, m_s2, m_prev, m_el;
    bit [2:0] m_t;
    bit       m_sf;
    bit [7:0] m_en, m_pri;
    bit [1:0] m_ins;
    bit       m_busy;
    int       m_win;
    bit       m_lvl;

    function automatic bit [5:0] m_req();
        bit [5:0] r;
        r[0] = ext_edge_mode[0] ? m_el[0] : !m_s2[0];
        r[2] = ext_edge_mode[1] ? m_el[1] : !m_s2[1];
        r[1] = m_t[0]; r[3] = m_t[1]; r[5] = m_t[2]; r[4] = m_sf;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 2'b11; m_s2 = 2'b11; m_prev = 2'b11; m_el = 0;
            m_t = 0; m_sf = 0; m_en = 0; m_pri = 0; m_ins = 0;
            m_busy = 0; m_win = 0; m_lvl = 0;
        end else begin
            bit [5:0] r;
            bit found, acc, f_lvl;
            bit [1:0] n_ins;
            int f_win;
            r = m_req();
            found = 0; f_win = 0; f_lvl = 0;
            acc = m_busy && call_ack;
            if (!m_busy && m_en[7]) begin
                for (int i = 0; i < 6; i++)
                    if (!found && r[i] && m_en[i] && m_pri[i] && !m_ins[1]) begin
                        found = 1; f_win = i; f_lvl = 1;
                    end
                for (int i = 0; i < 6; i++)
                    if (!found && r[i] && m_en[i] && !m_pri[i] && m_ins == 0) begin
                        found = 1; f_win = i; f_lvl = 0;
                    end
            end
            for (int e = 0; e < 2; e++) begin
                if (m_prev[e] && !m_s2[e]) m_el[e] = 1;
                else if (acc && m_win == 2*e) m_el[e] = 0;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin_n;
            for (int t = 0; t < 3; t++) begin
                if (tmr_ovf[t]) m_t[t] = 1;
                else if (acc && m_win == 2*t+1) m_t[t] = 0;
            end
            if (ser_set) m_sf = 1; else if (ser_clr) m_sf = 0;
            n_ins = m_ins;
            if (reti) begin if (m_ins[1]) n_ins[1] = 0; else n_ins[0] = 0; end
            if (acc) n_ins[m_lvl] = 1;
            m_ins = n_ins;
            if (en_we)  m_en  = en_wdata  & 8'hBF;
            if (pri_we) m_pri = pri_wdata & 8'h3F;
            if (acc) m_busy = 0;
            else if (found) begin m_busy = 1; m_win = f_win; m_lvl = f_lvl; end
        end
    end

    // compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(call_req == m_busy, "R4 R5 R8 model call_req", call_req, m_busy);
            if (m_busy)
                chk(call_vec == 16'(3 + 8*m_win), "R6 model call_vec", call_vec, 3 + 8*m_win);
            chk(flags == m_req(), "R10 R11 model flags", flags, m_req());
            chk(in_service == m_ins, "R9 model in_service", in_service, m_ins);
            chk(en_q == m_en && pri_q == m_pri, "R2 model regs", {en_q, pri_q}, {m_en, m_pri});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_en(input bit [7:0] v);
        en_we = 1; en_wdata = v; @(negedge clk); en_we = 0;
    endtask
    task automatic wr_pri(input bit [7:0] v);
        pri_we = 1; pri_wdata = v; @(negedge clk); pri_we = 0;
    endtask
    task automatic pulse_tmr(input int t);
        tmr_ovf[t] = 1; @(negedge clk); tmr_ovf[t] = 0;
    endtask
    task automatic pulse_ser(input bit clr);
        if (clr) ser_clr = 1; else ser_set = 1;
        @(negedge clk); ser_clr = 0; ser_set = 0;
    endtask
    task automatic do_reti();
        reti = 1; @(negedge clk); reti = 0; @(negedge clk);
    endtask
    task automatic expect_call(input bit [15:0] v, input string tag);
        int n = 0;
        while (!call_req && n < 40) begin @(negedge clk); n++; end
        chk(call_req == 1, {tag, " call raised"}, call_req, 1);
        chk(call_vec == v, {tag, " vector"}, call_vec, v);
        call_ack = 1; @(negedge clk); call_ack = 0;
    endtask
    task automatic expect_quiet(input int n, input string tag);
        bit seen = 0;
        repeat (n) begin @(negedge clk); if (call_req) seen = 1; end
        chk(!seen, {tag, " no call"}, seen, 0);
    endtask
    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(en_q == 0 && pri_q == 0, "R1 regs after reset", {en_q, pri_q}, 0);
        chk(flags == 0 && in_service == 0 && !call_req, "R1 flags/ins/call", {flags, in_service, call_req}, 0);

        // R2 masked bits
        wr_en(8'hFF); wr_pri(8'hFF); @(negedge clk);
        chk(en_q == 8'hBF, "R2 enable unused bit", en_q, 8'hBF);
        chk(pri_q == 8'h3F, "R2 priority unused bits", pri_q, 8'h3F);
        wr_en(8'h00); wr_pri(8'h00);

        // R3 global and per-source gating
        pulse_tmr(0);
        expect_quiet(8, "R3 global off");
        chk(flags[1] == 1, "R3 flag latched", flags[1], 1);
        wr_en(8'h80);
        expect_quiet(8, "R3 source off");
        wr_en(8'h82);
        expect_call(16'h000B, "R6 timer0");
        @(negedge clk);
        chk(flags[1] == 0, "R7 timer flag auto clear", flags[1], 0);
        do_reti();

        // R4 polling order, R7 serial sticky
        wr_en(8'h00);
        tmr_ovf = 3'b011; ser_set = 1; @(negedge clk); tmr_ovf = 0; ser_set = 0;
        wr_en(8'hBF);
        expect_call(16'h000B, "R4 first timer0");
        do_reti();
        expect_call(16'h001B, "R4 second timer1");
        do_reti();
        expect_call(16'h0023, "R4 third serial");
        repeat (2) @(negedge clk);
        chk(flags[4] == 1, "R7 serial not cleared by ack", flags[4], 1);
        pulse_ser(1); @(negedge clk);
        chk(flags[4] == 0, "R7 serial cleared by ser_clr", flags[4], 0);
        do_reti();

        // R5 high class beats lower index
        wr_en(8'h00); wr_pri(8'h10);
        tmr_ovf[0] = 1; ser_set = 1; @(negedge clk); tmr_ovf = 0; ser_set = 0;
        wr_en(8'h92);
        expect_call(16'h0023, "R5 high serial first");
        expect_quiet(8, "R8 low blocked under high");
        pulse_ser(1);
        do_reti();
        expect_call(16'h000B, "R5 then timer0");
        do_reti();

        // R8 preemption, R9 return order
        wr_en(8'h9A);
        pulse_tmr(0);
        expect_call(16'h000B, "R8 low handler");
        pulse_tmr(1);
        expect_quiet(8, "R8 low over low");
        pulse_ser(0);
        expect_call(16'h0023, "R8 high preempts");
        @(negedge clk);
        chk(in_service == 2'b11, "R8 both levels active", in_service, 2'b11);
        pulse_ser(1);
        do_reti();
        chk(in_service == 2'b01, "R9 reti clears high first", in_service, 2'b01);
        expect_quiet(5, "R8 timer1 still blocked");
        do_reti();
        expect_call(16'h001B, "R9 timer1 after return");
        do_reti();

        // R10 edge detection on external 0
        wr_en(8'h00); ext_edge_mode = 2'b01;
        ext_pin_n[0] = 0;
        repeat (2) @(negedge clk);
        chk(flags[0] == 0, "R10 not yet after two edges", flags[0], 0);
        @(negedge clk);
        chk(flags[0] == 1, "R10 set on third edge", flags[0], 1);
        wr_en(8'h81);
        expect_call(16'h0003, "R10 ext0 vector");
        repeat (2) @(negedge clk);
        chk(flags[0] == 0, "R7 edge flag cleared while pin low", flags[0], 0);
        do_reti();
        expect_quiet(6, "R10 no retrigger on steady low");
        ext_pin_n[0] = 1;

        // R11 level detection on external 1
        wr_en(8'h00); ext_edge_mode = 2'b00;
        ext_pin_n[1] = 0; repeat (3) @(negedge clk);
        chk(flags[2] == 1, "R11 level seen", flags[2], 1);
        ext_pin_n[1] = 1; repeat (3) @(negedge clk);
        chk(flags[2] == 0, "R11 level released", flags[2], 0);
        ext_pin_n[1] = 0;
        wr_en(8'h84);
        expect_call(16'h0013, "R11 ext1 vector");
        repeat (2) @(negedge clk);
        chk(flags[2] == 1, "R11 level not cleared by ack", flags[2], 1);
        ext_pin_n[1] = 1; repeat (3) @(negedge clk);
        do_reti();

        // R6 timer 2 vector
        wr_en(8'hA0);
        pulse_tmr(2);
        expect_call(16'h002B, "R6 timer2");
        do_reti();

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule